// File: doc/BRIEF.md
# Two-Lane Serial Audio Slave Receiver

This block receives serial audio in the I2S format as a slave. An external master drives one bit clock and one word select. Two serial data lines share them. Line 0 carries the front stereo pair and line 1 carries the rear pair. Every frame therefore delivers four samples: front-left, front-right, rear-left and rear-right.

The bit clock, the word select and both data lines pass through a two-flop synchronizer into the system clock domain. The system clock must run at least four times faster than the bit clock. Each word is captured as a 20-bit two's-complement value with the MSB first:

- A word shorter than 20 bits is padded with zeros in its LSBs.
- A word longer than 20 bits keeps its first 20 bits and discards the rest.

When a right-channel word ends, the four samples of the frame are published together. A single-cycle strobe marks them, and downstream logic reads them like a small register file.

Top module: `dual_i2s_rx`

## Requirements
- R1: A word sent while word select is low (0) is a left sample, and a word sent while word select is high (1) is a right sample. Left and right words never complete in the same system clock cycle.
- R2: The first data bit after a word-select change is the MSB of the new word and lands in bit 19. Each later bit lands one position lower. The bit sampled at the bit-clock rise that first shows the changed word select is the last bit of the word that is ending.
- R3: Serial data is sampled on rising bit-clock edges only. The bench changes data and word select on falling edges.
- R4: A word with fewer than 20 bits is stored with its received bits at the top and zeros in the missing LSBs.
- R5: A word with more than 20 bits is stored as its first 20 bits. Every bit after the 20th has no effect on the stored sample.
- R6: Data line 0 fills bits [19:0] of `left_o` and `right_o` (front pair). Data line 1 fills bits [39:20] (rear pair).
- R7: `frame_valid_o` is high for exactly one system clock cycle after each right word that follows a captured left word. All four samples change in that cycle and hold their values at all other times.
- R8: After reset, all outputs are zero and `frame_valid_o` is low. Words received before the first falling edge of word select never produce a strobe. The first frame published is the first left word plus right word that follow that falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External serial bit clock |
| ws_i | input | 1 | External word select, 0 = left, 1 = right |
| sd_i | input | 2 | Serial data; bit 0 = front line, bit 1 = rear line |
| left_o | output | 40 | Left samples; [19:0] front, [39:20] rear |
| right_o | output | 40 | Right samples; [19:0] front, [39:20] rear |
| frame_valid_o | output | 1 | One-cycle strobe: new four-sample set |

## Verification
On one bit-clock rise the block both captures the final bit of the ending word and recognizes the word-select change that closes that word. When that word is a right word, the same rise also launches the frame handoff. The bench provokes this overlap by sweeping the left-word length from 1 to 32 bits, with the right word making up the rest of a 33-bit frame. The sweep includes one-bit words, where the only bit and the word-select change share a rise. Each published sample is judged against the padded or trimmed value computed arithmetically from the driven word. A dropped or misplaced final bit shows up as an LSB mismatch.

// File: rtl/dual_i2s_pkg.sv
package dual_i2s_pkg;

    // Channel carried by a word, as signalled by word select
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int unsigned DEF_SAMPLE_W = 20;
    localparam int unsigned DEF_LINES    = 2;

endpackage

// File: rtl/i2s_in_sync.sv
module i2s_in_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = async_i;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stable;

endmodule

// File: rtl/i2s_frame_ctrl.sv
module i2s_frame_ctrl
    import dual_i2s_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned CW       = $clog2(SAMPLE_W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk_s,
    input  logic          ws_s,
    output logic          take_bit,
    output logic [CW-1:0] bit_pos,
    output logic          word_end,
    output logic          fin_left,
    output logic          fin_right,
    output logic          frame_valid
);

    typedef struct packed {
        logic          bclk_prev;
        chan_e         ws_last;
        logic          primed;
        logic          armed;
        logic          got_left;
        logic [CW-1:0] cnt;
        logic          valid;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic rise;
    logic ws_change;
    logic room;

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.bclk_prev = bclk_s;

        rise      = bclk_s & ~ctrl_q.bclk_prev;
        room      = (ctrl_q.cnt < CW'(SAMPLE_W));
        ws_change = rise & ctrl_q.primed & (chan_e'(ws_s) != ctrl_q.ws_last);
        fin_left  = ws_change & ctrl_q.armed & (ctrl_q.ws_last == CH_LEFT);
        fin_right = ws_change & ctrl_q.armed & ctrl_q.got_left
                    & (ctrl_q.ws_last == CH_RIGHT);

        if (rise) begin
            ctrl_d.primed  = 1'b1;
            ctrl_d.ws_last = chan_e'(ws_s);
            if (ws_change) begin
                ctrl_d.cnt = '0;
            end else if (room) begin
                ctrl_d.cnt = ctrl_q.cnt + CW'(1);
            end
            // a right word ending means word select fell: capture may start
            if (ws_change && (ctrl_q.ws_last == CH_RIGHT)) begin
                ctrl_d.armed = 1'b1;
            end
            if (fin_left) begin
                ctrl_d.got_left = 1'b1;
            end
        end

        ctrl_d.valid = fin_right;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign take_bit    = rise & room;
    assign bit_pos     = ctrl_q.cnt;
    assign word_end    = ws_change;
    assign frame_valid = ctrl_q.valid;

endmodule

// File: rtl/i2s_lane_capture.sv
module i2s_lane_capture
    import dual_i2s_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned CW       = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd_s,
    input  logic                take_bit,
    input  logic [CW-1:0]       bit_pos,
    input  logic                word_end,
    input  logic                fin_left,
    input  logic                fin_right,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o
);

    localparam logic [SAMPLE_W-1:0] MSB_ONE = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic [SAMPLE_W-1:0] word;
        logic [SAMPLE_W-1:0] hold;
        logic [SAMPLE_W-1:0] out_l;
        logic [SAMPLE_W-1:0] out_r;
    } lane_t;

    lane_t lane_d, lane_q;
    logic [SAMPLE_W-1:0] word_nx;

    always_comb begin
        lane_d  = lane_q;
        word_nx = lane_q.word;
        // word starts cleared, so untouched LSBs remain zero padding
        if (take_bit && sd_s) begin
            word_nx = lane_q.word | (MSB_ONE >> bit_pos);
        end
        lane_d.word = word_end ? '0 : word_nx;
        if (fin_left) begin
            lane_d.hold = word_nx;
        end
        if (fin_right) begin
            lane_d.out_l = lane_q.hold;
            lane_d.out_r = word_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign left_o  = lane_q.out_l;
    assign right_o = lane_q.out_r;

endmodule

// File: rtl/dual_i2s_rx.sv
module dual_i2s_rx
    import dual_i2s_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned LINES    = DEF_LINES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bclk_i,
    input  logic                      ws_i,
    input  logic [LINES-1:0]          sd_i,
    output logic [LINES*SAMPLE_W-1:0] left_o,
    output logic [LINES*SAMPLE_W-1:0] right_o,
    output logic                      frame_valid_o
);

    localparam int unsigned CW     = $clog2(SAMPLE_W + 1);
    localparam int unsigned SYNC_W = LINES + 2;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] syn_in;
    logic              take_bit;
    logic [CW-1:0]     bit_pos;
    logic              word_end;
    logic              fin_left;
    logic              fin_right;

    assign raw_in = {sd_i, ws_i, bclk_i};

    i2s_in_sync #(.W(SYNC_W)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    i2s_frame_ctrl #(.SAMPLE_W(SAMPLE_W), .CW(CW)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_s      (syn_in[0]),
        .ws_s        (syn_in[1]),
        .take_bit    (take_bit),
        .bit_pos     (bit_pos),
        .word_end    (word_end),
        .fin_left    (fin_left),
        .fin_right   (fin_right),
        .frame_valid (frame_valid_o)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_lane
        i2s_lane_capture #(.SAMPLE_W(SAMPLE_W), .CW(CW)) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sd_s      (syn_in[2+g]),
            .take_bit  (take_bit),
            .bit_pos   (bit_pos),
            .word_end  (word_end),
            .fin_left  (fin_left),
            .fin_right (fin_right),
            .left_o    (left_o[g*SAMPLE_W +: SAMPLE_W]),
            .right_o   (right_o[g*SAMPLE_W +: SAMPLE_W])
        );
    end

endmodule

// File: rtl/dual_i2s_rx_chk.sv
module dual_i2s_rx_chk #(
    parameter int unsigned SAMPLE_W = 20,
    parameter int unsigned LINES    = 2,
    parameter int unsigned CW       = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_valid,
    input logic [LINES*SAMPLE_W-1:0] left_q,
    input logic [LINES*SAMPLE_W-1:0] right_q,
    input logic                      take_bit,
    input logic [CW-1:0]             bit_pos,
    input logic                      word_end,
    input logic                      fin_left,
    input logic                      fin_right
);

    AST_SIDE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fin_left && fin_right)); // R1

    AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bit && !word_end) |=> (bit_pos == $past(bit_pos) + CW'(1))); // R2

    AST_WORD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> (bit_pos == '0)); // R4

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R7

    AST_VALID_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        fin_right |=> frame_valid); // R7

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(left_q) && $stable(right_q))); // R7

endmodule

bind dual_i2s_rx dual_i2s_rx_chk #(
    .SAMPLE_W (SAMPLE_W),
    .LINES    (LINES),
    .CW       (CW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid_o),
    .left_q      (left_o),
    .right_q     (right_o),
    .take_bit    (take_bit),
    .bit_pos     (bit_pos),
    .word_end    (word_end),
    .fin_left    (fin_left),
    .fin_right   (fin_right)
);

// File: tb/dual_i2s_rx_tb_top.sv
`timescale 1ns/1ps
module dual_i2s_rx_tb_top;

    localparam int SW = 20;
    localparam int NL = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bclk = 1'b1;
    logic            ws = 1'b0;
    logic [NL-1:0]   sd = '0;
    logic [NL*SW-1:0] left_o, right_o;
    logic            valid;

    int vectors = 0;
    int fails   = 0;
    int n_exp   = 0;
    int rx_idx  = 0;
    bit done    = 1'b0;
    bit prev_valid = 1'b0;

    logic [SW-1:0] e_fl [0:63];
    logic [SW-1:0] e_fr [0:63];
    logic [SW-1:0] e_rl [0:63];
    logic [SW-1:0] e_rr [0:63];
    int            e_nl [0:63];
    int            e_nr [0:63];

    dual_i2s_rx #(.SAMPLE_W(SW), .LINES(NL)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_i        (bclk),
        .ws_i          (ws),
        .sd_i          (sd),
        .left_o        (left_o),
        .right_o       (right_o),
        .frame_valid_o (valid)
    );

    always #2.5 clk = ~clk;

    function automatic string len_req(input int n);
        if (n < SW) return "R4";
        if (n > SW) return "R5";
        return "R2";
    endfunction

    function automatic logic [31:0] keep_n(input logic [31:0] v, input int n);
        return v & ~(32'hFFFF_FFFF << n);
    endfunction

    function automatic logic [SW-1:0] trim(input logic [31:0] v, input int n);
        logic [31:0] m;
        m = keep_n(v, n);
        if (n >= SW) return SW'(m >> (n - SW));
        return SW'(m << (SW - n));
    endfunction

    task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // R3: data and word select change only while the bit clock is low,
    // the receiver must take them on the following rising edge
    task automatic drive_bit(input logic w, input logic [NL-1:0] d);
        bclk = 1'b0;
        ws   = w;
        sd   = d;
        #20;
        bclk = 1'b1;
        #20;
    endtask

    // word select moves to the next channel during the last bit (R2)
    task automatic send_word(input logic ch, input int n,
                             input logic [31:0] v0, input logic [31:0] v1);
        for (int i = 0; i < n; i++) begin
            drive_bit((i == n - 1) ? ~ch : ch, {v1[n-1-i], v0[n-1-i]});
        end
    endtask

    task automatic send_frame(input int nl, input int nr,
                              input logic [31:0] fl, input logic [31:0] fr,
                              input logic [31:0] rl, input logic [31:0] rr);
        e_fl[n_exp] = trim(fl, nl);
        e_rl[n_exp] = trim(rl, nl);
        e_fr[n_exp] = trim(fr, nr);
        e_rr[n_exp] = trim(rr, nr);
        e_nl[n_exp] = nl;
        e_nr[n_exp] = nr;
        n_exp++;
        send_word(1'b0, nl, fl, rl);
        send_word(1'b1, nr, fr, rr);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                vectors++;
                if (prev_valid) begin
                    fails++;
                    $display("FAIL R7 strobe width act=2+ exp=1");
                end
                vectors++;
                if (rx_idx >= n_exp) begin
                    fails++;
                    $display("FAIL R8 unexpected strobe act=%0d exp<%0d", rx_idx, n_exp);
                end else begin
                    chk({"R1 front-left ", len_req(e_nl[rx_idx])},  left_o[SW-1:0],     e_fl[rx_idx]);
                    chk({"R1 front-right ", len_req(e_nr[rx_idx])}, right_o[SW-1:0],    e_fr[rx_idx]);
                    chk({"R6 rear-left ", len_req(e_nl[rx_idx])},   left_o[2*SW-1:SW],  e_rl[rx_idx]);
                    chk({"R6 rear-right ", len_req(e_nr[rx_idx])},  right_o[2*SW-1:SW], e_rr[rx_idx]);
                end
                rx_idx++;
            end
            prev_valid = valid;
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = 32'h1357_9BDF;
        #51;
        rst_n = 1'b1;
        #20;
        // R8: reset state
        chk("R8 left after reset",  left_o[SW-1:0] | left_o[2*SW-1:SW], '0);
        chk("R8 right after reset", right_o[SW-1:0] | right_o[2*SW-1:SW], '0);
        chk("R8 strobe after reset", SW'(valid), '0);

        // partial stream before the first falling word select: discarded
        drive_bit(1'b0, '0);
        send_word(1'b0, 20, 32'hABCDE, 32'h12345);
        send_word(1'b1, 24, 32'h777777, 32'h0F0F0F);
        #200;
        chk("R8 no strobe before arming", SW'(rx_idx), '0);

        // R3: directed frames with distinct line patterns
        send_frame(20, 20, 32'h80000, 32'h7FFFF, 32'hFFFFF, 32'h00001);
        send_frame(16, 24, 32'hBEEF, 32'hA5A5A5, 32'h8001, 32'hFFFFFF);
        send_frame(32, 8, 32'hDEADBEEF, 32'h81, 32'h0000_0FFF, 32'h7E);

        // sweep: left length 1..32, right fills a 33-bit frame
        for (int nl = 1; nl <= 32; nl++) begin
            logic [31:0] a, b, c, d;
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; c = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; d = seed;
            send_frame(nl, 33 - nl, a, b, c, d);
        end

        drive_bit(1'b0, '0);
        #400;
        chk("R7 frames published", SW'(rx_idx), SW'(n_exp));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule